// File: doc/BRIEF.md
# MDIO Management Command Controller

This block lets host software reach the management registers of an Ethernet PHY over the two-wire serial management interface defined in clause 22. Software writes a 16-bit command word. The word carries a PHY address, a register number and one operation bit: read or write. The controller then runs exactly one serial frame on the MDC/MDIO pins. The requested operation bit reads back as 1 for the whole frame and clears by itself at the end, so software polls the command word to find out when the frame has finished.

Data moves through two registers of its own. The value to send is loaded into the write-data register before the command is issued. The block copies that value when it accepts the command, so later writes to the register do not change the frame already running. A read shifts the 16 bits returned by the PHY into a capture register. That result becomes visible in the read-data register only when the frame completes.

MDC is produced by dividing the system clock. The divider sets how many system cycles each half of an MDC period lasts. MDC is held low whenever no frame is running.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: Register map on `bus_addr_i`: 0 is the command word, 1 is the read data, 2 is the write data, and 3 reads as zero. In the command word, bit 14 requests a write, bit 13 requests a read, bits 12:8 hold the PHY address and bits 4:0 hold the register number. The command word reads back as: bit 14 = write frame running, bit 13 = read frame running, bits 12:8 and 4:0 = the fields of the last accepted command, and all other bits 0.
- R2: A frame is 64 MDC bit times, sent MSB first in this order: 32 ones of preamble, start bits 0 then 1, an opcode (1,0 for read; 0,1 for write), the 5-bit PHY address, the 5-bit register number, 2 turnaround bits, and 16 data bits.
- R3: In a write frame, the turnaround bits are 1 then 0 and the data bits are the write-data value. The output enable stays high for all 64 bits.
- R4: After reset, and whenever no frame is running, MDC is low, the output enable is low, MDIO out is 1, and every register reads 0 until it is written. A frame lasts exactly 128*CLK_DIV_HALF system cycles counted from the accepting edge, and its operation bit reads 1 for exactly that time.
- R5: During a frame, MDC starts low and changes level every CLK_DIV_HALF system cycles. Each bit time is one low phase followed by one high phase.
- R6: MDIO out changes only while MDC is low.
- R7: In a read frame, the output enable drops at the first turnaround bit and stays low until the end of the frame. `mdio_i` is sampled at each rising MDC edge of the 16 data bits, and the assembled word appears in the read-data register once the frame completes.
- R8: A command word with both operation bits set, with neither bit set, or written while a frame is running (including the cycle in which a frame completes) is ignored: no frame starts and the command word readback does not change.
- R9: The write data sent in a frame is the write-data register value at the moment the command is accepted. Writes to that register during the frame change the register readback but not the bits on the wire.
- R10: The read-data register keeps its previous value during any frame. A write frame leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register select for reads and writes |
| bus_wdata_i | input | 16 | Register write data |
| bus_rdata_o | output | 16 | Readback of the selected register |
| mdc_o | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Serial data out |
| mdio_oe_o | output | 1 | Output enable for the MDIO pad |
| mdio_i | input | 1 | Serial data in from the pad |

## Verification
Two events can land on the same clock edge: a new command written by software, and the completion of the current frame (the operation bit clearing). The bench writes a valid command exactly in the last cycle of a read frame. Its cycle-accurate reference model, which treats the frame as still busy on that edge, expects the command to be dropped. The bench then checks that MDC stays idle, that the command readback shows neither operation bit, and that the read result is correct. A second collision, a write to the write-data register in the middle of a write frame, is judged by comparing every serial data bit against the value copied when the command was accepted.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int unsigned FRAME_BITS = 64;

    localparam logic [5:0] PREAMBLE_END = 6'd32;
    localparam logic [5:0] TA_FIRST     = 6'd46;
    localparam logic [5:0] DATA_FIRST   = 6'd48;
    localparam logic [5:0] LAST_BIT     = 6'd63;

    localparam logic [1:0] ADDR_CMD   = 2'd0;
    localparam logic [1:0] ADDR_RDATA = 2'd1;
    localparam logic [1:0] ADDR_WDATA = 2'd2;

    localparam int unsigned CMD_WR_BIT = 14;
    localparam int unsigned CMD_RD_BIT = 13;

    typedef struct packed {
        logic        is_read;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] wdata;
    } mdio_req_t;

    typedef struct packed {
        logic       busy;
        logic [5:0] bit_idx;
        mdio_req_t  req;
        logic [15:0] rx;
    } eng_state_t;

    typedef struct packed {
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] wdata;
        logic [15:0] rdata;
    } regs_state_t;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int unsigned HALF = 20
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic mdc_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int unsigned CW = $clog2(HALF) + 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } div_state_t;

    div_state_t q, d;

    always_comb begin
        d      = q;
        rise_o = 1'b0;
        fall_o = 1'b0;
        if (!run_i) begin
            d.cnt = '0;
            d.mdc = 1'b0;
        end else if (q.cnt == LAST) begin
            d.cnt  = '0;
            d.mdc  = !q.mdc;
            rise_o = !q.mdc;
            fall_o = q.mdc;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign mdc_o = q.mdc;

    // R5
    edge_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rise_o && fall_o));

    // R5
    mdc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && q.cnt != LAST) |=> $stable(mdc_o));

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        start_i,
    input  mdio_req_t   req_i,
    input  logic        rise_i,
    input  logic        fall_i,
    input  logic        mdio_i,
    output logic        busy_o,
    output logic        is_read_o,
    output logic        done_o,
    output logic [15:0] rx_o,
    output logic        mdio_o,
    output logic        mdio_oe_o
);
    eng_state_t q, d;
    logic [31:0] tail;
    logic        bit_val;

    always_comb begin
        tail = {2'b01, (q.req.is_read ? 2'b10 : 2'b01), q.req.phy, q.req.regad,
                2'b10, q.req.wdata};
        bit_val = (q.bit_idx < PREAMBLE_END) ? 1'b1 : tail[5'(LAST_BIT - q.bit_idx)];
    end

    always_comb begin
        d      = q;
        done_o = 1'b0;
        if (!q.busy) begin
            if (start_i) begin
                d.busy    = 1'b1;
                d.bit_idx = '0;
                d.req     = req_i;
            end
        end else begin
            if (rise_i && q.req.is_read && q.bit_idx >= DATA_FIRST) begin
                d.rx = {q.rx[14:0], mdio_i};
            end
            if (fall_i) begin
                if (q.bit_idx == LAST_BIT) begin
                    d.busy    = 1'b0;
                    d.bit_idx = '0;
                    done_o    = 1'b1;
                end else begin
                    d.bit_idx = q.bit_idx + 6'd1;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign busy_o    = q.busy;
    assign is_read_o = q.req.is_read;
    assign rx_o      = q.rx;
    assign mdio_o    = q.busy ? bit_val : 1'b1;
    assign mdio_oe_o = q.busy && (!q.req.is_read || q.bit_idx < TA_FIRST);

    // R2
    bit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.busy && fall_i && q.bit_idx != LAST_BIT) |=> (q.bit_idx == $past(q.bit_idx) + 6'd1));

    // R9
    req_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.busy && $past(q.busy)) |-> $stable(q.req));

endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
    import mdio_pkg::*;
#(
    parameter int unsigned CLK_DIV_HALF = 20
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        bus_wr_i,
    input  logic [1:0]  bus_addr_i,
    input  logic [15:0] bus_wdata_i,
    output logic [15:0] bus_rdata_o,
    output logic        mdc_o,
    output logic        mdio_o,
    output logic        mdio_oe_o,
    input  logic        mdio_i
);
    regs_state_t q, d;

    logic        eng_busy, eng_is_read, eng_done;
    logic [15:0] eng_rx;
    logic        rise, fall;
    logic        cmd_wr, start;
    mdio_req_t   req;
    logic        unused_cmd_bits;

    assign unused_cmd_bits = ^{bus_wdata_i[15], bus_wdata_i[7:5]};

    assign cmd_wr = bus_wr_i && (bus_addr_i == ADDR_CMD);
    assign start  = cmd_wr && !eng_busy &&
                    (bus_wdata_i[CMD_WR_BIT] ^ bus_wdata_i[CMD_RD_BIT]);

    always_comb begin
        req.is_read = bus_wdata_i[CMD_RD_BIT];
        req.phy     = bus_wdata_i[12:8];
        req.regad   = bus_wdata_i[4:0];
        req.wdata   = q.wdata;
    end

    always_comb begin
        d = q;
        if (start) begin
            d.phy   = req.phy;
            d.regad = req.regad;
        end
        if (bus_wr_i && bus_addr_i == ADDR_WDATA) begin
            d.wdata = bus_wdata_i;
        end
        if (eng_done && eng_is_read) begin
            d.rdata = eng_rx;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    always_comb begin
        unique case (bus_addr_i)
            ADDR_CMD:   bus_rdata_o = {1'b0, eng_busy && !eng_is_read, eng_busy && eng_is_read,
                                       q.phy, 3'b000, q.regad};
            ADDR_RDATA: bus_rdata_o = q.rdata;
            ADDR_WDATA: bus_rdata_o = q.wdata;
            default:    bus_rdata_o = '0;
        endcase
    end

    mdio_clk_div #(.HALF(CLK_DIV_HALF)) i_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (eng_busy),
        .mdc_o  (mdc_o),
        .rise_o (rise),
        .fall_o (fall)
    );

    mdio_frame_engine i_eng (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start),
        .req_i     (req),
        .rise_i    (rise),
        .fall_i    (fall),
        .mdio_i    (mdio_i),
        .busy_o    (eng_busy),
        .is_read_o (eng_is_read),
        .done_o    (eng_done),
        .rx_o      (eng_rx),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe_o)
    );

    // R6
    mdio_low_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$stable(mdio_o) || !$stable(mdio_oe_o)) |-> !mdc_o);

    // R4
    mdc_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !eng_busy |-> (!mdc_o && !mdio_oe_o));

    // R8
    busy_cmd_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eng_busy && cmd_wr) |=> ($stable(q.phy) && $stable(q.regad)));

    // R10
    rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eng_busy && !eng_done) |=> $stable(q.rdata));

endmodule

// File: tb/test_mdio_cmd_ctrl.sv
module test_mdio_cmd_ctrl;
    localparam int H     = 2;
    localparam int FRAME = 128 * H;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        mdc, mdio_out, mdio_oe;
    logic        mdio_in = 1'b0;

    always #2 clk = ~clk;

    mdio_cmd_ctrl #(.CLK_DIV_HALF(H)) i_mdio_cmd_ctrl (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_wr_i    (bus_wr),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .mdc_o       (mdc),
        .mdio_o      (mdio_out),
        .mdio_oe_o   (mdio_oe),
        .mdio_i      (mdio_in)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // behavioural reference state
    bit          m_active;
    int          m_k;
    bit          m_rd;
    logic [4:0]  m_phy, m_reg;
    logic [15:0] m_wdata, m_snap, m_rdata, m_cap, m_pat;
    bit          was_active;

    function automatic logic exp_bit(int b);
        logic [31:0] t;
        t = {2'b01, (m_rd ? 2'b10 : 2'b01), m_phy, m_reg, 2'b10, m_snap};
        if (b < 32) return 1'b1;
        return t[63 - b];
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_active = 0; m_k = 0; m_rd = 0; m_phy = '0; m_reg = '0;
            m_wdata = '0; m_snap = '0; m_rdata = '0; m_cap = '0;
        end else begin
            was_active = m_active;
            if (m_active) begin
                m_k++;
                if ((m_k % (2*H)) == H && m_rd && (m_k / (2*H)) >= 48)
                    m_cap = {m_cap[14:0], mdio_in};
                if (m_k == FRAME) begin
                    m_active = 0;
                    if (m_rd) m_rdata = m_cap;
                end
            end
            if (bus_wr && bus_addr == 2'd0 && !was_active && (bus_wdata[14] ^ bus_wdata[13])) begin
                m_active = 1; m_k = 0; m_rd = bus_wdata[13];
                m_phy = bus_wdata[12:8]; m_reg = bus_wdata[4:0]; m_snap = m_wdata;
            end
            if (bus_wr && bus_addr == 2'd2) m_wdata = bus_wdata;
        end
    end

    // per-cycle comparison away from the active edge, then PHY model drive
    always @(negedge clk) begin
        if (rst_n) begin
            int b;
            logic [15:0] exp_bus;
            b = m_k / (2*H);
            if (m_active) begin
                chk("R5 mdc", {15'b0, mdc}, {15'b0, 1'((m_k / H) % 2)});
                chk(m_rd ? "R7 oe" : "R3 oe", {15'b0, mdio_oe}, {15'b0, (!m_rd || b < 46)});
                if (!m_rd || b < 46)
                    chk(m_rd ? "R2 mdio" : "R3 mdio", {15'b0, mdio_out}, {15'b0, exp_bit(b)});
            end else begin
                chk("R4 idle pins", {13'b0, mdc, mdio_oe, mdio_out}, 16'h0001);
            end
            case (bus_addr)
                2'd0: exp_bus = {1'b0, m_active && !m_rd, m_active && m_rd, m_phy, 3'b000, m_reg};
                2'd1: exp_bus = m_rdata;
                2'd2: exp_bus = m_wdata;
                default: exp_bus = 16'h0;
            endcase
            chk(bus_addr == 2'd0 ? "R1/R4 cmd" : (bus_addr == 2'd1 ? "R10 rdata" : "R1 wdata"),
                bus_rdata, exp_bus);
            if (m_active && m_rd && b >= 48) mdio_in = m_pat[63 - b];
            else mdio_in = cyc[0];
        end
    end

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic bus_write(logic [1:0] a, logic [15:0] v);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic set_addr(logic [1:0] a);
        @(posedge clk); #1;
        bus_addr = a;
    endtask

    task automatic wait_idle();
        do begin @(posedge clk); #1; end while (m_active);
    endtask

    task automatic wait_k(int k);
        do begin @(posedge clk); #1; end while (!(m_active && m_k == k));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    initial begin
        m_pat = 16'h0;
        idle(5);
        #1 rst_n = 1'b1;
        idle(5);                               // R4 reset state

        // R3 write frame, R9 wdata change mid-frame, R8 command while busy
        bus_write(2'd2, 16'hA5C3);
        bus_write(2'd0, 16'h4000 | (16'd5 << 8) | 16'h0011);
        wait_k(40);
        bus_write(2'd2, 16'hFFFF);             // R9
        bus_write(2'd0, 16'h2302);             // R8
        set_addr(2'd0);
        wait_idle();
        idle(6);

        // R7 read frame, R2 header fields
        m_pat = 16'h8143;
        bus_write(2'd0, 16'h2000 | 16'h1F02);
        wait_idle();
        set_addr(2'd1);
        idle(6);

        // R8 both bits, then neither bit
        bus_write(2'd0, 16'h6000 | 16'h0A0A);
        set_addr(2'd0);
        idle(20);
        bus_write(2'd0, 16'h0105);
        idle(20);

        // R8 command in the completion cycle of a read
        m_pat = 16'h7E18;
        bus_write(2'd0, 16'h2000 | 16'h0A1C);
        wait_k(FRAME - 1);
        bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 16'h4101;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        idle(12);
        set_addr(2'd1);
        idle(4);

        // R10 write frame leaves read data alone
        bus_write(2'd2, 16'h0001);
        bus_write(2'd0, 16'h401F);
        set_addr(2'd1);
        wait_idle();
        idle(6);

        finish_run();
    end
endmodule